// File: doc/BRIEF.md
# UART Register Front End

This block gives a processor bus a view of a UART: a transmit queue, a receive queue and an 8-bit baud clock divisor, all inside one 256-byte window of a 32-bit address space. The bus is a plain single-cycle interface. One cycle carries an address, a write strobe with a data byte, and a read strobe. Read data comes back from a register on the following cycle. Bus writes push bytes onto the transmit queue or load the divisor. Bus reads pop the receive queue, take a snapshot of the queue flags, or return the divisor.

Both queues sit inside the block. Each one is a small circular buffer whose depth is a parameter. The serial shifter lives elsewhere and connects through valid/ready handshakes: the block offers transmit bytes to the shifter, and it accepts received bytes from it. The divisor is driven out as a port for the baud generator.

The bus write data port carries only the byte that the block stores. No register in the window holds more than eight bits.

Top module: `uart_regbank`

## Requirements
- R1: The block responds only when address bits 31..8 equal the parameter BASE_HI (default 0xC00020). A write outside the window changes no state. A read outside the window leaves the read data register unchanged.
- R2: A write at offset 0x00 pushes the write data byte onto the transmit queue. Bytes leave on tx_data in push order, one per cycle in which tx_valid and tx_ready are both high. While tx_valid is high and tx_ready is low, tx_data holds steady.
- R3: A write at offset 0x00 while the transmit queue holds DEPTH bytes drops the byte and leaves the queue contents unchanged.
- R4: A write at offset 0x18 loads the divisor from the write data byte. The divisor is driven on baud_div. A read at offset 0x18 returns the divisor zero-extended to 32 bits.
- R5: A read at offset 0x10 returns the status word: bit 3 = transmit queue full, bit 2 = receive queue full, bit 1 = transmit queue empty, bit 0 = receive queue empty. All other bits are zero.
- R6: A byte is taken into the receive queue in every cycle in which rx_valid and rx_ready are both high. rx_ready is low exactly when the receive queue is full. A read at offset 0x00 returns the oldest received byte, zero-extended, and removes it from the queue on the same clock edge.
- R7: A read at offset 0x00 while the receive queue is empty returns zero and removes nothing.
- R8: A read at any other offset in the window returns zero. A write at any offset other than 0x00 and 0x18 changes no state.
- R9: Read data appears on bus_rdata in the cycle after the read request. It holds its value in every cycle that follows a cycle with no read in the window.
- R10: After reset both queues are empty, tx_valid is low, rx_ready is high, bus_rdata is zero and baud_div equals the parameter DIV_RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| baud_div | output | 8 | Current baud clock divisor |
| tx_valid | output | 1 | Transmit queue has a byte for the shifter |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Shifter takes the transmit byte |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Receive queue can take a byte |

## Verification
The assertions assume that the serial side changes rx_valid and rx_data only between clock edges, and that reset is held for at least one edge before the first bus access. The assertions do not depend on a bus access being a read or a write alone. The bench drives every input on the falling edge and pulses reset for several cycles at the start. Its bus tasks raise a single strobe for exactly one cycle, so at no point does a read and a write to the same register collide.

// File: rtl/ureg_pkg.sv
package ureg_pkg;

    localparam logic [7:0] OFF_DATA = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_DIV  = 8'h18;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STAT = 2'd2,
        SEL_DIV  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } access_t;

    // packing order fixes the bit positions: tx_full is bit 3, rx_empty bit 0
    typedef struct packed {
        logic tx_full;
        logic rx_full;
        logic tx_empty;
        logic rx_empty;
    } status_t;

    function automatic access_t decode_addr(input logic [31:0] addr,
                                            input logic [23:0] base_hi);
        access_t r;
        r.hit = (addr[31:8] == base_hi);
        unique case (addr[7:0])
            OFF_DATA: r.sel = SEL_DATA;
            OFF_STAT: r.sel = SEL_STAT;
            OFF_DIV:  r.sel = SEL_DIV;
            default:  r.sel = SEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ureg_fifo.sv
module ureg_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW:0]  wp, rp;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    assign empty   = (wp == rp);
    assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp[AW-1:0]] <= push_data;
    end

endmodule

// File: rtl/ureg_decode.sv
module ureg_decode
    import ureg_pkg::*;
#(
    parameter logic [23:0] BASE_HI = 24'hC00020
) (
    input  logic [31:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic        tx_push_req,
    output logic        div_load,
    output logic        rd_hit,
    output logic        rd_data_req,
    output reg_sel_e    rd_sel
);
    access_t acc;

    always_comb begin
        acc         = decode_addr(bus_addr, BASE_HI);
        tx_push_req = bus_wr && acc.hit && (acc.sel == SEL_DATA);
        div_load    = bus_wr && acc.hit && (acc.sel == SEL_DIV);
        rd_hit      = bus_rd && acc.hit;
        rd_data_req = rd_hit && (acc.sel == SEL_DATA);
        rd_sel      = acc.sel;
    end

endmodule

// File: rtl/ureg_readmux.sv
module ureg_readmux
    import ureg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  reg_sel_e          sel,
    input  status_t           status,
    input  logic [7:0]        divisor,
    input  logic [7:0]        rx_head,
    input  logic              rx_empty,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word = '0;
        unique case (sel)
            SEL_DATA: if (!rx_empty) word[7:0] = rx_head;
            SEL_STAT: word[3:0] = status;
            SEL_DIV:  word[7:0] = divisor;
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import ureg_pkg::*;
#(
    parameter logic [23:0] BASE_HI   = 24'hC00020,
    parameter int          DEPTH     = 4,
    parameter logic [7:0]  DIV_RESET = 8'd16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic [7:0]  baud_div,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready
);
    logic       tx_push_req, div_load, rd_hit, rd_data_req;
    reg_sel_e   rd_sel;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic       rx_pop;
    logic [7:0] rx_head;
    logic [31:0] rd_word;
    status_t    status;

    ureg_decode #(.BASE_HI(BASE_HI)) u_dec (
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .tx_push_req (tx_push_req),
        .div_load    (div_load),
        .rd_hit      (rd_hit),
        .rd_data_req (rd_data_req),
        .rd_sel      (rd_sel)
    );

    ureg_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push_req),
        .push_data (bus_wdata),
        .pop       (tx_valid && tx_ready),
        .head      (tx_data),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    assign rx_pop = rd_data_req && !rx_empty;

    ureg_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    always_comb begin
        status.tx_full  = tx_full;
        status.rx_full  = rx_full;
        status.tx_empty = tx_empty;
        status.rx_empty = rx_empty;
    end

    ureg_readmux #(.DATA_W(32)) u_rmux (
        .sel      (rd_sel),
        .status   (status),
        .divisor  (baud_div),
        .rx_head  (rx_head),
        .rx_empty (rx_empty),
        .word     (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_div  <= DIV_RESET;
            bus_rdata <= '0;
        end else begin
            if (div_load) baud_div  <= bus_wdata;
            if (rd_hit)   bus_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
    parameter logic [23:0] BASE_HI   = 24'hC00020,
    parameter logic [7:0]  DIV_RESET = 8'd16
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [31:0] bus_rdata,
    input logic [7:0]  baud_div,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_ready,
    input logic        rx_ready,
    input logic        rx_pop,
    input logic        rx_empty
);
    // R10: reset state seen right after reset is released
    a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (baud_div == DIV_RESET && !tx_valid && rx_ready && bus_rdata == 32'd0));

    // R2: offered transmit byte holds while not taken
    a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R4 / R1 / R8: divisor changes only through a write to its own offset in the window
    a_r4_div_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == {BASE_HI, 8'h18}) |=> $stable(baud_div));

    // R9: read data holds when no read in the window was made
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_addr[31:8] == BASE_HI) |=> $stable(bus_rdata));

    // R7: never remove from an empty receive queue
    a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !rx_empty);

    // R7: empty data read returns zero
    a_r7_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == {BASE_HI, 8'h00} && rx_empty) |=> (bus_rdata == 32'd0));

endmodule

bind uart_regbank uart_regbank_chk #(.BASE_HI(BASE_HI), .DIV_RESET(DIV_RESET)) u_chk (.*);

// File: tb/uart_regbank_test.sv
module uart_regbank_test;
    localparam logic [31:0] BASE  = 32'hC0002000;
    localparam int          DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  baud_div;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;

    int checks = 0;
    int fails  = 0;
    int txc = 0;
    int rxc = 0;
    logic [7:0] cur_div = 8'd16;

    always #2 clk = ~clk;

    uart_regbank #(.BASE_HI(24'hC00020), .DEPTH(DEPTH), .DIV_RESET(8'd16)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .baud_div(baud_div), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] status_exp(input int t, input int r);
        return {28'd0, t == DEPTH, r == DEPTH, t == 0, r == 0};
    endfunction

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset values
        chk("R10 div", {24'd0, baud_div}, 32'd16);
        chk("R10 tx_valid", {31'd0, tx_valid}, 0);
        chk("R10 rx_ready", {31'd0, rx_ready}, 1);
        chk("R10 rdata", bus_rdata, 0);
        rd(BASE | 32'h10);
        chk("R5 status after reset", bus_rdata, status_exp(0, 0));

        // R4 divisor write and readback
        wr(BASE | 32'h18, 8'hB5); cur_div = 8'hB5;
        chk("R4 baud_div", {24'd0, baud_div}, 32'hB5);
        rd(BASE | 32'h18);
        chk("R4 readback", bus_rdata, 32'hB5);

        // R1 out-of-window writes have no effect
        wr(32'hC0003018, 8'h11);
        wr(32'h40002000, 8'h22);
        chk("R1 div kept", {24'd0, baud_div}, {24'd0, cur_div});
        chk("R1 no tx push", {31'd0, tx_valid}, 0);
        // R1 out-of-window read keeps rdata
        rd(32'hC0012010);
        chk("R1 rdata held", bus_rdata, 32'hB5);

        // R8 sweep of unmapped write offsets
        for (int o = 0; o < 256; o++) begin
            if (o != 8'h00 && o != 8'h18) begin
                wr(BASE | o, 8'(o ^ 8'h5A));
                if (baud_div !== cur_div || tx_valid !== 1'b0)
                    chk("R8 write ignored", {23'd0, tx_valid, baud_div}, {24'd0, cur_div});
            end
        end
        chk("R8 write sweep div", {24'd0, baud_div}, {24'd0, cur_div});

        // R8/R5/R4/R7 read sweep of every offset
        for (int o = 0; o < 256; o++) begin
            logic [31:0] e;
            rd(BASE | o);
            if (o == 8'h10) e = status_exp(0, 0);
            else if (o == 8'h18) e = {24'd0, cur_div};
            else e = 0;
            if (bus_rdata !== e) chk("R8 read sweep", bus_rdata, e);
        end
        checks++;

        // R9 read data appears one cycle after request
        bus_addr = BASE | 32'h18; bus_rd = 1'b1;
        chk("R9 before edge", bus_rdata, 0);
        @(negedge clk); bus_rd = 1'b0;
        chk("R9 after edge", bus_rdata, {24'd0, cur_div});
        @(negedge clk);
        chk("R9 hold", bus_rdata, {24'd0, cur_div});

        // R2/R3 fill transmit queue with shifter stalled
        for (int i = 0; i < DEPTH + 2; i++) begin
            wr(BASE, 8'(8'h30 + i));
            if (txc < DEPTH) txc++;
        end
        chk("R2 tx_valid", {31'd0, tx_valid}, 1);
        chk("R2 head stalled", {24'd0, tx_data}, 32'h30);
        rd(BASE | 32'h10);
        chk("R5 tx full status", bus_rdata, status_exp(txc, rxc));
        tx_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 drain order", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'(8'h30 + i)});
            @(negedge clk);
        end
        txc = 0;
        chk("R3 extra dropped", {31'd0, tx_valid}, 0);
        tx_ready = 1'b0;

        // R7 empty receive read
        rd(BASE | 32'h18);
        rd(BASE);
        chk("R7 empty read zero", bus_rdata, 0);

        // R6 fill receive queue
        for (int i = 0; i < DEPTH + 1; i++) begin
            rx_valid = 1'b1; rx_data = 8'(8'hA0 + i);
            if (rxc < DEPTH) chk("R6 rx_ready", {31'd0, rx_ready}, 1);
            else chk("R6 rx_ready full", {31'd0, rx_ready}, 0);
            @(negedge clk);
            if (rxc < DEPTH) rxc++;
        end
        rx_valid = 1'b0;
        rd(BASE | 32'h10);
        chk("R5 rx full status", bus_rdata, status_exp(txc, rxc));
        for (int i = 0; i < DEPTH; i++) begin
            rd(BASE);
            chk("R6 rx order", bus_rdata, {24'd0, 8'(8'hA0 + i)});
            rxc--;
        end
        rd(BASE);
        chk("R7 read after drain", bus_rdata, 0);
        rd(BASE | 32'h10);
        chk("R5 final status", bus_rdata, status_exp(txc, rxc));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule